// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard controller for a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. It takes the register indices, valid bits and instruction class flags of the decode, execute, memory and write-back stages. From them it works out whether decode must wait, which bypass path each execute operand should take, and whether the store data held in the memory stage must be replaced by the write-back result. It also drives the kill signals that remove younger instructions after a redirect. It is purely control: the ALU, register file, memories and branch target logic sit outside and only consume its outputs.

A mode input selects full bypassing or a configuration where only the register file's write-then-read path is left. In the second mode every dependency on an instruction still in execute or memory holds decode until the producer reaches write-back. Two free-running counters, of stall cycles and of retired instructions, let a test confirm the cycle cost of a known instruction sequence.

Top module: `hzd_unit`

## Requirements
- R1: Register index 0 never causes a hold, an execute or store-data bypass, or a register-file write-through flag, whatever the stage valid and write flags are.
- R2: With `fwd_en`=1, an execute operand whose index matches a valid writing non-load instruction in memory gets select 2'b01. Otherwise, if it matches a valid writing instruction in write-back, it gets 2'b10. With no match it gets 2'b00. Memory wins when both stages match.
- R3: With `fwd_en`=1, a decode source (rs1, or rs2 of a non-store) that matches a load in execute raises `pc_hold`, `ifid_hold` and `idex_bubble` for that cycle. Once the load has moved to memory, the same decode instruction is not held.
- R4: With `fwd_en`=0, all bypass selects are 2'b00 and `mem_sel_sd` is 0. Any used decode source (the store data source included) that matches a writing instruction in execute or in memory holds decode. An adjacent dependency therefore costs two hold cycles.
- R5: `id_wt_a`/`id_wt_b` are 1 when decode's rs1/rs2 is used and equals the register being written by a valid write-back instruction, in either mode.
- R6: With `fwd_en`=1, a store's data source (rs2) never causes a hold. A store in memory whose rs2 equals the write-back destination gets `mem_sel_sd`=1. A store's address source (rs1) still obeys R3.
- R7: A load in the memory stage is never a bypass source for execute. The operand instead takes 2'b10 one cycle later from write-back.
- R8: A valid unconditional jump in decode (`id_jump`) raises `ifid_flush` only: one younger instruction is killed, with no bubble and no hold, even when a hold condition is also present.
- R9: A taken conditional branch in execute (`ex_br_taken`) raises `ifid_flush` and `idex_bubble`, killing two younger instructions. It forces `pc_hold` and `ifid_hold` to 0.
- R10: `stall_cnt` increments on every clock edge with `pc_hold`=1, and `retire_cnt` on every edge with `wb_valid`=1.
- R11: While `rst_n` is low both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | 1 = full bypassing, 0 = register-file write-through only |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_rs1 | input | REG_W | Decode source 1 index |
| id_rs2 | input | REG_W | Decode source 2 index |
| id_use_rs1 | input | 1 | Decode instruction reads source 1 |
| id_use_rs2 | input | 1 | Decode instruction reads source 2 |
| id_is_store | input | 1 | Decode instruction is a store (rs2 is store data) |
| id_jump | input | 1 | Decode instruction is an unconditional jump |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_rs1 | input | REG_W | Execute source 1 index |
| ex_rs2 | input | REG_W | Execute source 2 index |
| ex_use_rs1 | input | 1 | Execute instruction reads source 1 |
| ex_use_rs2 | input | 1 | Execute instruction reads source 2 |
| ex_rd | input | REG_W | Execute destination index |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_br_taken | input | 1 | Conditional branch in execute resolved taken |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_rs2 | input | REG_W | Memory-stage store data source index |
| mem_rd | input | REG_W | Memory-stage destination index |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| wb_valid | input | 1 | Write-back stage holds an instruction |
| wb_rd | input | REG_W | Write-back destination index |
| wb_wr | input | 1 | Write-back instruction writes a register |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode pipeline register |
| ifid_flush | output | 1 | Load a bubble into the fetch/decode register |
| idex_bubble | output | 1 | Load a bubble (all control zero) into the decode/execute register |
| ex_sel_a | output | 2 | Execute operand 1 source: 00 pipeline, 01 memory, 10 write-back |
| ex_sel_b | output | 2 | Execute operand 2 / store data source, same encoding |
| mem_sel_sd | output | 1 | Replace memory-stage store data with the write-back result |
| id_wt_a | output | 1 | Decode source 1 reads the value being written back |
| id_wt_b | output | 1 | Decode source 2 reads the value being written back |
| stall_cnt | output | CNT_W | Hold cycles since reset |
| retire_cnt | output | CNT_W | Write-back instructions since reset |

## Verification
Nearly all of the block is combinational, so a wrong comparison or priority shows at the ports in the same cycle as the stage contents that trigger it. One example is a load used as a bypass source from memory: it would give select 01 where 00 is due. Another is a hold that misses rd=0 filtering. The stall and retire counters are the only stored state. An error in them appears one edge after the hold or write-back cycle it concerns, and it stays visible in every later sample. Multi-cycle stories such as the two-cycle hold without bypassing are checked by stepping the stage contents as a real pipeline would advance them.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef enum logic [1:0] {
      SEL_RF  = 2'b00,
      SEL_MEM = 2'b01,
      SEL_WB  = 2'b10
   } fwd_sel_e;

   localparam int NUM_SRC = 2;
endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
   parameter int REG_W = 5
) (
   input  logic             valid,
   input  logic             wr,
   input  logic [REG_W-1:0] rd,
   input  logic [REG_W-1:0] src,
   input  logic             use_src,
   output logic             hit
);
   localparam logic [REG_W-1:0] ZERO_REG = '0;

   // a producer writing register zero is never a real dependency
   assign hit = valid && wr && use_src && (rd != ZERO_REG) && (rd == src);
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
   import hzd_pkg::*;
#(
   parameter int NSRC = 2
) (
   input  logic                 fwd_en,
   input  logic                 mem_is_load,
   input  logic [NSRC-1:0]      hit_mem,
   input  logic [NSRC-1:0]      hit_wb,
   input  logic                 sd_hit,
   output logic [NSRC-1:0][1:0] sel,
   output logic                 sd_sel
);
   // load data does not exist until the end of memory: never bypass it from there
   for (genvar g = 0; g < NSRC; g++) begin : g_op
      assign sel[g] = !fwd_en                      ? SEL_RF  :
                      (hit_mem[g] && !mem_is_load) ? SEL_MEM :
                      hit_wb[g]                    ? SEL_WB  : SEL_RF;
   end

   assign sd_sel = fwd_en && sd_hit;
endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl #(
   parameter int NSRC = 2
) (
   input  logic            fwd_en,
   input  logic            id_valid,
   input  logic            id_is_store,
   input  logic            id_jump,
   input  logic            ex_is_load,
   input  logic            ex_br_taken,
   input  logic [NSRC-1:0] hit_ex,
   input  logic [NSRC-1:0] hit_mem,
   output logic            pc_hold,
   output logic            ifid_hold,
   output logic            ifid_flush,
   output logic            idex_bubble
);
   logic dep_fwd;
   logic dep_nofwd;
   logic raw_dep;
   logic kill_any;
   logic stall;

   // with bypassing only a load one ahead forces a wait; store data is consumed late
   assign dep_fwd   = ex_is_load && (hit_ex[0] || (hit_ex[1] && !id_is_store));
   assign dep_nofwd = (|hit_ex) || (|hit_mem);
   assign raw_dep   = fwd_en ? dep_fwd : dep_nofwd;

   assign kill_any  = (id_valid && id_jump) || ex_br_taken;
   assign stall     = raw_dep && !kill_any;

   assign pc_hold     = stall;
   assign ifid_hold   = stall;
   assign ifid_flush  = kill_any;
   assign idex_bubble = stall || ex_br_taken;
endmodule

// File: rtl/hzd_counters.sv
module hzd_counters #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stall_inc,
   input  logic             retire_inc,
   output logic [CNT_W-1:0] stall_cnt,
   output logic [CNT_W-1:0] retire_cnt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall_cnt  <= '0;
         retire_cnt <= '0;
      end else begin
         if (stall_inc)  stall_cnt  <= stall_cnt + ONE;
         if (retire_inc) retire_cnt <= retire_cnt + ONE;
      end
   end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
   import hzd_pkg::*;
#(
   parameter int REG_W = 5,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fwd_en,
   input  logic             id_valid,
   input  logic [REG_W-1:0] id_rs1,
   input  logic [REG_W-1:0] id_rs2,
   input  logic             id_use_rs1,
   input  logic             id_use_rs2,
   input  logic             id_is_store,
   input  logic             id_jump,
   input  logic             ex_valid,
   input  logic [REG_W-1:0] ex_rs1,
   input  logic [REG_W-1:0] ex_rs2,
   input  logic             ex_use_rs1,
   input  logic             ex_use_rs2,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             ex_wr,
   input  logic             ex_is_load,
   input  logic             ex_br_taken,
   input  logic             mem_valid,
   input  logic [REG_W-1:0] mem_rs2,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_wr,
   input  logic             mem_is_load,
   input  logic             mem_is_store,
   input  logic             wb_valid,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_wr,
   output logic             pc_hold,
   output logic             ifid_hold,
   output logic             ifid_flush,
   output logic             idex_bubble,
   output logic [1:0]       ex_sel_a,
   output logic [1:0]       ex_sel_b,
   output logic             mem_sel_sd,
   output logic             id_wt_a,
   output logic             id_wt_b,
   output logic [CNT_W-1:0] stall_cnt,
   output logic [CNT_W-1:0] retire_cnt
);
   localparam int NSRC = NUM_SRC;

   if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
      $error("hzd_unit: REG_W must be 1..8");
   end
   if (CNT_W < 4) begin : g_bad_cnt_w
      $error("hzd_unit: CNT_W must be at least 4");
   end

   logic [NSRC-1:0][REG_W-1:0] id_src;
   logic [NSRC-1:0][REG_W-1:0] ex_src;
   logic [NSRC-1:0]            id_use;
   logic [NSRC-1:0]            ex_use;
   logic [NSRC-1:0]            id_hit_ex;
   logic [NSRC-1:0]            id_hit_mem;
   logic [NSRC-1:0]            id_hit_wb;
   logic [NSRC-1:0]            ex_hit_mem;
   logic [NSRC-1:0]            ex_hit_wb;
   logic [NSRC-1:0][1:0]       ex_sel;
   logic                       sd_hit;

   assign id_src = {id_rs2, id_rs1};
   assign ex_src = {ex_rs2, ex_rs1};
   assign id_use = {id_use_rs2, id_use_rs1};
   assign ex_use = {ex_use_rs2, ex_use_rs1};

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      hzd_match #(.REG_W(REG_W)) u_id_ex (
         .valid(id_valid && ex_valid), .wr(ex_wr), .rd(ex_rd),
         .src(id_src[g]), .use_src(id_use[g]), .hit(id_hit_ex[g]));
      hzd_match #(.REG_W(REG_W)) u_id_mem (
         .valid(id_valid && mem_valid), .wr(mem_wr), .rd(mem_rd),
         .src(id_src[g]), .use_src(id_use[g]), .hit(id_hit_mem[g]));
      hzd_match #(.REG_W(REG_W)) u_id_wb (
         .valid(id_valid && wb_valid), .wr(wb_wr), .rd(wb_rd),
         .src(id_src[g]), .use_src(id_use[g]), .hit(id_hit_wb[g]));
      hzd_match #(.REG_W(REG_W)) u_ex_mem (
         .valid(ex_valid && mem_valid), .wr(mem_wr), .rd(mem_rd),
         .src(ex_src[g]), .use_src(ex_use[g]), .hit(ex_hit_mem[g]));
      hzd_match #(.REG_W(REG_W)) u_ex_wb (
         .valid(ex_valid && wb_valid), .wr(wb_wr), .rd(wb_rd),
         .src(ex_src[g]), .use_src(ex_use[g]), .hit(ex_hit_wb[g]));
   end

   hzd_match #(.REG_W(REG_W)) u_sd (
      .valid(mem_valid && wb_valid), .wr(wb_wr), .rd(wb_rd),
      .src(mem_rs2), .use_src(mem_is_store), .hit(sd_hit));

   hzd_fwd_sel #(.NSRC(NSRC)) u_fwd (
      .fwd_en(fwd_en), .mem_is_load(mem_is_load),
      .hit_mem(ex_hit_mem), .hit_wb(ex_hit_wb), .sd_hit(sd_hit),
      .sel(ex_sel), .sd_sel(mem_sel_sd));

   hzd_stall_ctl #(.NSRC(NSRC)) u_stall (
      .fwd_en(fwd_en), .id_valid(id_valid), .id_is_store(id_is_store),
      .id_jump(id_jump), .ex_is_load(ex_is_load), .ex_br_taken(ex_br_taken),
      .hit_ex(id_hit_ex), .hit_mem(id_hit_mem),
      .pc_hold(pc_hold), .ifid_hold(ifid_hold),
      .ifid_flush(ifid_flush), .idex_bubble(idex_bubble));

   hzd_counters #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .stall_inc(pc_hold), .retire_inc(wb_valid),
      .stall_cnt(stall_cnt), .retire_cnt(retire_cnt));

   assign ex_sel_a = ex_sel[0];
   assign ex_sel_b = ex_sel[1];
   // register file writes early in the cycle, so this path ignores fwd_en
   assign id_wt_a  = id_hit_wb[0];
   assign id_wt_b  = id_hit_wb[1];
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
   parameter int REG_W = 5,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fwd_en,
   input logic             id_valid,
   input logic [REG_W-1:0] id_rs1,
   input logic [REG_W-1:0] id_rs2,
   input logic             id_use_rs1,
   input logic             id_use_rs2,
   input logic             id_is_store,
   input logic             id_jump,
   input logic             ex_valid,
   input logic [REG_W-1:0] ex_rs1,
   input logic [REG_W-1:0] ex_rs2,
   input logic             ex_use_rs1,
   input logic             ex_use_rs2,
   input logic [REG_W-1:0] ex_rd,
   input logic             ex_wr,
   input logic             ex_is_load,
   input logic             ex_br_taken,
   input logic             mem_valid,
   input logic [REG_W-1:0] mem_rs2,
   input logic [REG_W-1:0] mem_rd,
   input logic             mem_wr,
   input logic             mem_is_load,
   input logic             mem_is_store,
   input logic             wb_valid,
   input logic [REG_W-1:0] wb_rd,
   input logic             wb_wr,
   input logic             pc_hold,
   input logic             ifid_hold,
   input logic             ifid_flush,
   input logic             idex_bubble,
   input logic [1:0]       ex_sel_a,
   input logic [1:0]       ex_sel_b,
   input logic             mem_sel_sd,
   input logic             id_wt_a,
   input logic             id_wt_b,
   input logic [CNT_W-1:0] stall_cnt,
   input logic [CNT_W-1:0] retire_cnt
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_zero_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_rs1 == '0) |-> (ex_sel_a == 2'b00));

   p_sel_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_sel_a != 2'b11) && (ex_sel_b != 2'b11));

   p_hold_bubble_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |-> (ifid_hold && idex_bubble));

   p_nofwd_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !fwd_en |-> (ex_sel_a == 2'b00 && ex_sel_b == 2'b00 && !mem_sel_sd));

   p_wt_needs_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (id_wt_a || id_wt_b) |-> (wb_valid && wb_wr && wb_rd != '0));

   p_sd_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_sel_sd |-> (mem_valid && mem_is_store && fwd_en));

   p_no_mem_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_is_load |-> (ex_sel_a != 2'b01 && ex_sel_b != 2'b01));

   p_jump_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (id_valid && id_jump && !ex_br_taken) |-> (ifid_flush && !idex_bubble && !pc_hold));

   p_branch_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ex_br_taken |-> (ifid_flush && idex_bubble && !pc_hold && !ifid_hold));

   p_stall_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(pc_hold)) |-> (stall_cnt == $past(stall_cnt) + CNT_W'(1)));

   p_retire_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(wb_valid)) |-> $stable(retire_cnt));
endmodule

bind hzd_unit hzd_unit_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_hzd_unit.sv
module test_hzd_unit;
   localparam int REG_W = 5;
   localparam int CNT_W = 16;
   localparam time TCLK = 20ns;

   typedef struct {
      logic fwd_en;
      logic id_valid; logic [REG_W-1:0] id_rs1; logic [REG_W-1:0] id_rs2;
      logic id_use_rs1; logic id_use_rs2; logic id_is_store; logic id_jump;
      logic ex_valid; logic [REG_W-1:0] ex_rs1; logic [REG_W-1:0] ex_rs2;
      logic ex_use_rs1; logic ex_use_rs2; logic [REG_W-1:0] ex_rd;
      logic ex_wr; logic ex_is_load; logic ex_br_taken;
      logic mem_valid; logic [REG_W-1:0] mem_rs2; logic [REG_W-1:0] mem_rd;
      logic mem_wr; logic mem_is_load; logic mem_is_store;
      logic wb_valid; logic [REG_W-1:0] wb_rd; logic wb_wr;
   } stim_t;

   // hold, flush, bubble, sel_a, sel_b, sd, wt_a, wt_b
   typedef struct packed {
      logic hold; logic flush; logic bubble;
      logic [1:0] sa; logic [1:0] sb;
      logic sd; logic wa; logic wb;
   } exp_t;

   typedef struct {
      exp_t  e;
      int    n_stall;
      int    n_ret;
      string tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   stim_t s;

   logic pc_hold, ifid_hold, ifid_flush, idex_bubble, mem_sel_sd, id_wt_a, id_wt_b;
   logic [1:0] ex_sel_a, ex_sel_b;
   logic [CNT_W-1:0] stall_cnt, retire_cnt;

   int checks = 0;
   int failures = 0;
   int exp_stall = 0;
   int exp_ret = 0;
   bit done = 1'b0;
   item_t q[$];

   always #(TCLK/2) clk = ~clk;

   hzd_unit #(.REG_W(REG_W), .CNT_W(CNT_W)) i_hzd_unit (
      .clk(clk), .rst_n(rst_n), .fwd_en(s.fwd_en),
      .id_valid(s.id_valid), .id_rs1(s.id_rs1), .id_rs2(s.id_rs2),
      .id_use_rs1(s.id_use_rs1), .id_use_rs2(s.id_use_rs2),
      .id_is_store(s.id_is_store), .id_jump(s.id_jump),
      .ex_valid(s.ex_valid), .ex_rs1(s.ex_rs1), .ex_rs2(s.ex_rs2),
      .ex_use_rs1(s.ex_use_rs1), .ex_use_rs2(s.ex_use_rs2), .ex_rd(s.ex_rd),
      .ex_wr(s.ex_wr), .ex_is_load(s.ex_is_load), .ex_br_taken(s.ex_br_taken),
      .mem_valid(s.mem_valid), .mem_rs2(s.mem_rs2), .mem_rd(s.mem_rd),
      .mem_wr(s.mem_wr), .mem_is_load(s.mem_is_load), .mem_is_store(s.mem_is_store),
      .wb_valid(s.wb_valid), .wb_rd(s.wb_rd), .wb_wr(s.wb_wr),
      .pc_hold(pc_hold), .ifid_hold(ifid_hold), .ifid_flush(ifid_flush),
      .idex_bubble(idex_bubble), .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
      .mem_sel_sd(mem_sel_sd), .id_wt_a(id_wt_a), .id_wt_b(id_wt_b),
      .stall_cnt(stall_cnt), .retire_cnt(retire_cnt));

   function automatic stim_t idle(input logic fwd);
      stim_t t;
      t = '{default: '0};
      t.fwd_en = fwd;
      return t;
   endfunction

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // driver: apply one set of stage contents and queue what must appear
   task automatic step(input stim_t st, input exp_t e, input string tag);
      item_t it;
      @(negedge clk);
      s = st;
      #1;
      it.e = e; it.n_stall = exp_stall; it.n_ret = exp_ret; it.tag = tag;
      q.push_back(it);
      exp_stall += int'(e.hold);
      exp_ret   += int'(st.wb_valid);
   endtask

   // monitor: compare outputs mid-cycle, counters show the edges before
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (q.size() > 0) begin
            item_t it;
            exp_t  act;
            it = q.pop_front();
            act = '{hold: pc_hold & ifid_hold, flush: ifid_flush, bubble: idex_bubble,
                    sa: ex_sel_a, sb: ex_sel_b, sd: mem_sel_sd, wa: id_wt_a, wb: id_wt_b};
            checks++;
            if (act !== it.e || pc_hold !== ifid_hold) begin
               failures++;
               $display("FAIL %s outputs actual=%b hold_pair=%b%b expected=%b",
                        it.tag, act, pc_hold, ifid_hold, it.e);
            end
            checks++;
            if (int'(stall_cnt) != it.n_stall || int'(retire_cnt) != it.n_ret) begin
               failures++;
               $display("FAIL R10 counters actual=%0d/%0d expected=%0d/%0d",
                        stall_cnt, retire_cnt, it.n_stall, it.n_ret);
            end
         end
      end
   end

   initial begin
      #(TCLK * 150000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

   initial begin
      stim_t t;
      s = idle(1'b1);
      // R11: reset state, with a would-be hold and write-back present
      s.id_valid = 1; s.id_use_rs1 = 1; s.id_rs1 = 5'd6;
      s.ex_valid = 1; s.ex_wr = 1; s.ex_is_load = 1; s.ex_rd = 5'd6; s.wb_valid = 1;
      repeat (3) @(negedge clk);
      #3;
      checks++;
      if (stall_cnt !== '0 || retire_cnt !== '0) begin
         failures++;
         $display("FAIL R11 counters in reset actual=%0d/%0d expected=0/0", stall_cnt, retire_cnt);
      end
      s = idle(1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // idle pipeline
      step(idle(1'b1), '{default: '0}, "R2 idle");

      // R2 memory bypass for operand a
      t = idle(1'b1);
      t.ex_valid = 1; t.ex_use_rs1 = 1; t.ex_rs1 = 5'd3;
      t.mem_valid = 1; t.mem_wr = 1; t.mem_rd = 5'd3;
      step(t, '{hold:0, flush:0, bubble:0, sa:2'b01, sb:2'b00, sd:0, wa:0, wb:0}, "R2 mem");

      // R2 memory wins over write-back
      t = idle(1'b1);
      t.ex_valid = 1; t.ex_use_rs2 = 1; t.ex_rs2 = 5'd4;
      t.mem_valid = 1; t.mem_wr = 1; t.mem_rd = 5'd4;
      t.wb_valid = 1; t.wb_wr = 1; t.wb_rd = 5'd4;
      step(t, '{hold:0, flush:0, bubble:0, sa:2'b00, sb:2'b01, sd:0, wa:0, wb:0}, "R2 priority");

      // R2 write-back bypass
      t = idle(1'b1);
      t.ex_valid = 1; t.ex_use_rs1 = 1; t.ex_rs1 = 5'd5;
      t.wb_valid = 1; t.wb_wr = 1; t.wb_rd = 5'd5;
      step(t, '{hold:0, flush:0, bubble:0, sa:2'b10, sb:2'b00, sd:0, wa:0, wb:0}, "R2 wb");

      // R1 register zero everywhere
      t = idle(1'b1);
      t.id_valid = 1; t.id_use_rs1 = 1; t.id_use_rs2 = 1;
      t.ex_valid = 1; t.ex_use_rs1 = 1; t.ex_wr = 1; t.ex_is_load = 1;
      t.mem_valid = 1; t.mem_wr = 1; t.mem_is_store = 1;
      t.wb_valid = 1; t.wb_wr = 1;
      step(t, '{default: '0}, "R1 zero");
      t.fwd_en = 0;
      step(t, '{default: '0}, "R1 zero nofwd");

      // R3 load-use on rs1 and on rs2 of a non-store
      t = idle(1'b1);
      t.id_valid = 1; t.id_use_rs1 = 1; t.id_rs1 = 5'd6;
      t.ex_valid = 1; t.ex_wr = 1; t.ex_is_load = 1; t.ex_rd = 5'd6;
      step(t, '{hold:1, flush:0, bubble:1, sa:2'b00, sb:2'b00, sd:0, wa:0, wb:0}, "R3 rs1");
      t.id_use_rs1 = 0; t.id_use_rs2 = 1; t.id_rs2 = 5'd6; t.id_rs1 = 5'd0;
      step(t, '{hold:1, flush:0, bubble:1, sa:2'b00, sb:2'b00, sd:0, wa:0, wb:0}, "R3 rs2");
      // R3 load moved to memory: single stall only
      t = idle(1'b1);
      t.id_valid = 1; t.id_use_rs1 = 1; t.id_rs1 = 5'd6;
      t.mem_valid = 1; t.mem_wr = 1; t.mem_is_load = 1; t.mem_rd = 5'd6;
      step(t, '{default: '0}, "R3 after stall");

      // R7 load in memory is not a bypass source, write-back is next cycle
      t = idle(1'b1);
      t.ex_valid = 1; t.ex_use_rs1 = 1; t.ex_rs1 = 5'd6;
      t.mem_valid = 1; t.mem_wr = 1; t.mem_is_load = 1; t.mem_rd = 5'd6;
      step(t, '{default: '0}, "R7 mem load");
      t = idle(1'b1);
      t.ex_valid = 1; t.ex_use_rs1 = 1; t.ex_rs1 = 5'd6;
      t.wb_valid = 1; t.wb_wr = 1; t.wb_rd = 5'd6;
      step(t, '{hold:0, flush:0, bubble:0, sa:2'b10, sb:2'b00, sd:0, wa:0, wb:0}, "R7 wb load");

      // R6 store data after load: no hold; store address after load: hold
      t = idle(1'b1);
      t.id_valid = 1; t.id_is_store = 1; t.id_use_rs1 = 1; t.id_rs1 = 5'd2;
      t.id_use_rs2 = 1; t.id_rs2 = 5'd7;
      t.ex_valid = 1; t.ex_wr = 1; t.ex_is_load = 1; t.ex_rd = 5'd7;
      step(t, '{default: '0}, "R6 store data");
      t.id_rs1 = 5'd7;
      step(t, '{hold:1, flush:0, bubble:1, sa:2'b00, sb:2'b00, sd:0, wa:0, wb:0}, "R6 store addr");
      // R6 late store-data bypass from write-back
      t = idle(1'b1);
      t.mem_valid = 1; t.mem_is_store = 1; t.mem_rs2 = 5'd7;
      t.wb_valid = 1; t.wb_wr = 1; t.wb_rd = 5'd7;
      step(t, '{hold:0, flush:0, bubble:0, sa:2'b00, sb:2'b00, sd:1, wa:0, wb:0}, "R6 sd");
      // R4 same without bypassing
      t.fwd_en = 0;
      step(t, '{default: '0}, "R4 sd off");

      // R4 no-forwarding sequence: two holds, then write-through
      t = idle(1'b0);
      t.id_valid = 1; t.id_use_rs1 = 1; t.id_rs1 = 5'd8;
      t.ex_valid = 1; t.ex_wr = 1; t.ex_rd = 5'd8;
      step(t, '{hold:1, flush:0, bubble:1, sa:2'b00, sb:2'b00, sd:0, wa:0, wb:0}, "R4 hold1");
      t.ex_valid = 0; t.ex_wr = 0; t.ex_rd = 5'd0;
      t.mem_valid = 1; t.mem_wr = 1; t.mem_rd = 5'd8;
      step(t, '{hold:1, flush:0, bubble:1, sa:2'b00, sb:2'b00, sd:0, wa:0, wb:0}, "R4 hold2");
      t.mem_valid = 0; t.mem_wr = 0; t.mem_rd = 5'd0;
      t.wb_valid = 1; t.wb_wr = 1; t.wb_rd = 5'd8;
      step(t, '{hold:0, flush:0, bubble:0, sa:2'b00, sb:2'b00, sd:0, wa:1, wb:0}, "R4 R5 release");
      // R4 execute bypass suppressed, store data dependency holds
      t = idle(1'b0);
      t.ex_valid = 1; t.ex_use_rs1 = 1; t.ex_rs1 = 5'd3;
      t.mem_valid = 1; t.mem_wr = 1; t.mem_rd = 5'd3;
      step(t, '{default: '0}, "R4 no bypass");
      t = idle(1'b0);
      t.id_valid = 1; t.id_is_store = 1; t.id_use_rs2 = 1; t.id_rs2 = 5'd7;
      t.ex_valid = 1; t.ex_wr = 1; t.ex_rd = 5'd7;
      step(t, '{hold:1, flush:0, bubble:1, sa:2'b00, sb:2'b00, sd:0, wa:0, wb:0}, "R4 store");

      // R5 write-through with bypassing on, and not for register zero (R1)
      t = idle(1'b1);
      t.id_valid = 1; t.id_use_rs2 = 1; t.id_rs2 = 5'd9;
      t.wb_valid = 1; t.wb_wr = 1; t.wb_rd = 5'd9;
      step(t, '{hold:0, flush:0, bubble:0, sa:2'b00, sb:2'b00, sd:0, wa:0, wb:1}, "R5 wt");
      t.id_rs2 = 5'd0; t.wb_rd = 5'd0;
      step(t, '{default: '0}, "R1 wt zero");

      // R8 jump kills one younger instruction, wins over a hold
      t = idle(1'b1);
      t.id_valid = 1; t.id_jump = 1;
      step(t, '{hold:0, flush:1, bubble:0, sa:2'b00, sb:2'b00, sd:0, wa:0, wb:0}, "R8 jump");
      t.id_use_rs1 = 1; t.id_rs1 = 5'd6;
      t.ex_valid = 1; t.ex_wr = 1; t.ex_is_load = 1; t.ex_rd = 5'd6;
      step(t, '{hold:0, flush:1, bubble:0, sa:2'b00, sb:2'b00, sd:0, wa:0, wb:0}, "R8 jump vs hold");

      // R9 taken branch kills two, wins over a hold
      t = idle(1'b1);
      t.ex_valid = 1; t.ex_br_taken = 1;
      step(t, '{hold:0, flush:1, bubble:1, sa:2'b00, sb:2'b00, sd:0, wa:0, wb:0}, "R9 branch");
      t = idle(1'b0);
      t.id_valid = 1; t.id_use_rs1 = 1; t.id_rs1 = 5'd8;
      t.ex_valid = 1; t.ex_br_taken = 1;
      t.mem_valid = 1; t.mem_wr = 1; t.mem_rd = 5'd8;
      step(t, '{hold:0, flush:1, bubble:1, sa:2'b00, sb:2'b00, sd:0, wa:0, wb:0}, "R9 branch vs hold");

      // R10 final counter view after the last queued item
      step(idle(1'b1), '{default: '0}, "R10 final");
      repeat (2) @(negedge clk);
      finish_up();
   end
endmodule